// File: doc/BRIEF.md
# Reversible-Gate 4x4 Crosswise Multiplier

This block multiplies two unsigned 4-bit operands into an 8-bit product. The arithmetic is built only from gate models that are one-to-one: each has as many outputs as inputs, and each can be inverted. Gate inputs that are not needed for the function are tied to constant zero. The outputs that the function does not need are collected as waste. No net drives more than one gate input. When an operand bit is needed in two places, a controlled-NOT gate with a zero target makes the second copy.

The operands are split into halves. Four 2x2 cells form the vertical and crosswise sub-products. Three reversible ripple adders then sum these sub-products. The cross terms are aligned at bit 2 and the high-by-high term at bit 4. In each adder, the bottom position has no carry in, so it uses a Peres gate as a half adder. Every position above it uses a reversible full-adder gate. The product and the waste vector are registered, and a synchronous active-high reset clears both.

Top module: `rvm_mul4`

## Requirements
- R1: On every rising edge with `rst` low, `p` takes the unsigned product `a*b` of the operands present at that edge. The product is valid for all 256 operand pairs.
- R2: On a rising edge with `rst` high, `p` and `waste` become all zeros, whatever the operand values.
- R3: The two low product bits come straight from the low-by-low cell: `p[0] = a[0]&b[0]` and `p[1] = (a[1]&b[0]) ^ (a[0]&b[1])`.
- R4: A 2x2 cell (`rvm_cell2`) outputs the 4-bit product of its two 2-bit operands for all 16 pairs. It uses one dual-product gate, three Peres gates and one controlled-NOT gate.
- R5: A W-bit reversible adder (`rvm_radd`) outputs the (W+1)-bit sum of its operands. Position 0 is a Peres half adder and each higher position is a full-adder gate. In the multiplier, the top bit of the first adder and the carry out of the last adder are always zero.
- R6: Every gate kind of `rvm_gate` is one-to-one over its full input space. Lane k of `in_i`/`out_o` is gate pin A, B, C, D, E for k = 0..4, and the lane count is 2, 3, 3, 3, 4, 5 for controlled-NOT, Toffoli, Peres, swap-xor, full-adder and dual-product.
- R7: Controlled-NOT gives P=A, Q=A^B. Toffoli gives P=A, Q=B, R=(A&B)^C.
- R8: Peres gives P=A, Q=A^B, R=(A&B)^C. With C=0, Q is the half-adder sum and R is the carry.
- R9: The full-adder gate gives P=A, Q=B, R=A^B^C, S=((A^B)&C)^(A&B)^D. With D=0, R is the sum and S is the carry out.
- R10: The dual-product gate gives P=A, Q=B, R=(A&B)^C, S=D, T=(A&D)^E. The swap-xor gate gives Q = (A ? C : B), R = (A ? B : C) and P = A^Q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 4 | Multiplicand |
| b | input | 4 | Multiplier |
| p | output | 8 | Registered product |
| waste | output | 43 | Registered garbage outputs of all gates, plus the two adder bits that are always zero |

## Verification
Two functions can land on the same edge: the reset clear and a fresh product capture. The bench sets the largest operands (15 x 15) and raises `rst` in the same cycle. It expects zero after that edge and 225 one edge after `rst` drops, so a reset that loses to the data path, or one that leaves stale state, is seen at `p`. Each primitive's equations and its one-to-one mapping are swept over its whole input space. The cell and the adder are also swept exhaustively, on their own, before the 256-pair sweep of the full multiplier.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

  localparam int OP_W     = 4;
  localparam int HALF_W   = OP_W / 2;
  localparam int SUB_W    = 2 * HALF_W;
  localparam int PROD_W   = 2 * OP_W;
  localparam int CELL_GW  = 5;
  localparam int ADD_GW   = 2 * SUB_W - 1;
  localparam int WASTE_W  = 4 * CELL_GW + 3 * ADD_GW + 2;

  typedef enum logic [2:0] {
    GK_CNOT,
    GK_TOFFOLI,
    GK_PERES,
    GK_SWAPXOR,
    GK_FULLADD,
    GK_DUALAND
  } gate_kind_e;

  function automatic int gate_lanes(gate_kind_e k);
    case (k)
      GK_CNOT:                          return 2;
      GK_TOFFOLI, GK_PERES, GK_SWAPXOR: return 3;
      GK_FULLADD:                       return 4;
      default:                          return 5;
    endcase
  endfunction

endpackage

// File: rtl/rvm_gate.sv
module rvm_gate import rvm_pkg::*; #(
  parameter gate_kind_e KIND = GK_PERES,
  localparam int LANES = gate_lanes(KIND)
) (
  input  logic [LANES-1:0] in_i,
  output logic [LANES-1:0] out_o
);

  // lane 0..4 = pin A..E on the input side, P..T on the output side
  if (KIND == GK_CNOT) begin : g_cnot
    assign out_o = {in_i[0] ^ in_i[1], in_i[0]};
  end else if (KIND == GK_TOFFOLI) begin : g_toffoli
    assign out_o = {(in_i[0] & in_i[1]) ^ in_i[2], in_i[1], in_i[0]};
  end else if (KIND == GK_PERES) begin : g_peres
    assign out_o = {(in_i[0] & in_i[1]) ^ in_i[2], in_i[0] ^ in_i[1], in_i[0]};
  end else if (KIND == GK_SWAPXOR) begin : g_swapxor
    logic sel_q, sel_r;
    assign sel_q = in_i[0] ? in_i[2] : in_i[1];
    assign sel_r = in_i[0] ? in_i[1] : in_i[2];
    assign out_o = {sel_r, sel_q, in_i[0] ^ sel_q};
  end else if (KIND == GK_FULLADD) begin : g_fulladd
    logic hx;
    assign hx    = in_i[0] ^ in_i[1];
    assign out_o = {(hx & in_i[2]) ^ (in_i[0] & in_i[1]) ^ in_i[3],
                    hx ^ in_i[2], in_i[1], in_i[0]};
  end else begin : g_dualand
    assign out_o = {(in_i[0] & in_i[3]) ^ in_i[4], in_i[3],
                    (in_i[0] & in_i[1]) ^ in_i[2], in_i[1], in_i[0]};
  end

endmodule

// File: rtl/rvm_cell2.sv
module rvm_cell2 import rvm_pkg::*; (
  input  logic [HALF_W-1:0]  a_i,
  input  logic [HALF_W-1:0]  b_i,
  output logic [SUB_W-1:0]   q_o,
  output logic [CELL_GW-1:0] junk_o
);

  logic x_t, y_t, z_t, hi_t;
  logic a0_c, b0_c, b1_c;
  logic q0, q1, q2, q3;
  logic g_a1, g_p1q, g_p2p, g_p2q, g_p3p;

  // a1&b1 and a1&b0 in one gate; b1 and b0 re-emerge as copies
  rvm_gate #(.KIND(GK_DUALAND)) u_dual (
    .in_i ({1'b0, b_i[0], 1'b0, b_i[1], a_i[1]}),
    .out_o({x_t, b0_c, z_t, b1_c, g_a1})
  );

  // a0&b0 with a copy of a0 passed on
  rvm_gate #(.KIND(GK_PERES)) u_low (
    .in_i ({1'b0, b0_c, a_i[0]}),
    .out_o({q0, g_p1q, a0_c})
  );

  // a0&b1 from the two copies
  rvm_gate #(.KIND(GK_PERES)) u_cross (
    .in_i ({1'b0, b1_c, a0_c}),
    .out_o({y_t, g_p2q, g_p2p})
  );

  // cross terms: sum bit and their AND (which equals the top product bit)
  rvm_gate #(.KIND(GK_PERES)) u_mix (
    .in_i ({1'b0, y_t, x_t}),
    .out_o({hi_t, q1, g_p3p})
  );

  rvm_gate #(.KIND(GK_CNOT)) u_top (
    .in_i ({z_t, hi_t}),
    .out_o({q2, q3})
  );

  assign q_o    = {q3, q2, q1, q0};
  assign junk_o = {g_p3p, g_p2p, g_p2q, g_p1q, g_a1};

endmodule

// File: rtl/rvm_radd.sv
module rvm_radd import rvm_pkg::*; #(
  parameter int W = 4,
  localparam int JW = 2 * W - 1
) (
  input  logic [W-1:0]  x_i,
  input  logic [W-1:0]  y_i,
  output logic [W:0]    sum_o,
  output logic [JW-1:0] junk_o
);

  logic [W:1]   cy;
  logic [W-1:0] s;

  for (genvar i = 0; i < W; i++) begin : g_pos
    if (i == 0) begin : g_half
      rvm_gate #(.KIND(GK_PERES)) u_ha (
        .in_i ({1'b0, y_i[0], x_i[0]}),
        .out_o({cy[1], s[0], junk_o[0]})
      );
    end else begin : g_full
      rvm_gate #(.KIND(GK_FULLADD)) u_fa (
        .in_i ({1'b0, cy[i], y_i[i], x_i[i]}),
        .out_o({cy[i+1], s[i], junk_o[2*i], junk_o[2*i-1]})
      );
    end
  end

  assign sum_o = {cy[W], s};

endmodule

// File: rtl/rvm_mul4.sv
module rvm_mul4 import rvm_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    a,
  input  logic [OP_W-1:0]    b,
  output logic [PROD_W-1:0]  p,
  output logic [WASTE_W-1:0] waste
);

  logic [OP_W-1:0]    a_x, a_y, b_x, b_y;
  logic [SUB_W-1:0]   q_ll, q_hl, q_lh, q_hh;
  logic [CELL_GW-1:0] w_ll, w_hl, w_lh, w_hh;
  logic [SUB_W:0]     s1, s2, s3;
  logic [ADD_GW-1:0]  j1, j2, j3;
  logic [PROD_W-1:0]  prod_d;
  logic [WASTE_W-1:0] waste_d;

  // operand copies through zero-target controlled-NOT gates
  for (genvar i = 0; i < OP_W; i++) begin : g_copy
    rvm_gate #(.KIND(GK_CNOT)) u_acp (.in_i({1'b0, a[i]}), .out_o({a_y[i], a_x[i]}));
    rvm_gate #(.KIND(GK_CNOT)) u_bcp (.in_i({1'b0, b[i]}), .out_o({b_y[i], b_x[i]}));
  end

  rvm_cell2 u_ll (.a_i(a_x[HALF_W-1:0]),    .b_i(b_x[HALF_W-1:0]),    .q_o(q_ll), .junk_o(w_ll));
  rvm_cell2 u_hl (.a_i(a_x[OP_W-1:HALF_W]), .b_i(b_y[HALF_W-1:0]),    .q_o(q_hl), .junk_o(w_hl));
  rvm_cell2 u_lh (.a_i(a_y[HALF_W-1:0]),    .b_i(b_x[OP_W-1:HALF_W]), .q_o(q_lh), .junk_o(w_lh));
  rvm_cell2 u_hh (.a_i(a_y[OP_W-1:HALF_W]), .b_i(b_y[OP_W-1:HALF_W]), .q_o(q_hh), .junk_o(w_hh));

  // weight-4 column: upper half of low-by-low plus one cross term
  rvm_radd #(.W(SUB_W)) u_add1 (
    .x_i(q_hl), .y_i({{HALF_W{1'b0}}, q_ll[SUB_W-1:HALF_W]}), .sum_o(s1), .junk_o(j1)
  );
  // second cross term joins at the same weight
  rvm_radd #(.W(SUB_W)) u_add2 (
    .x_i(q_lh), .y_i(s1[SUB_W-1:0]), .sum_o(s2), .junk_o(j2)
  );
  // weight-16 column: high-by-high plus the spill of the cross sum
  rvm_radd #(.W(SUB_W)) u_add3 (
    .x_i(q_hh), .y_i({1'b0, s2[SUB_W:HALF_W]}), .sum_o(s3), .junk_o(j3)
  );

  assign prod_d  = {s3[SUB_W-1:0], s2[HALF_W-1:0], q_ll[HALF_W-1:0]};
  assign waste_d = {s3[SUB_W], s1[SUB_W], j3, j2, j1, w_hh, w_lh, w_hl, w_ll};

  always_ff @(posedge clk) begin
    if (rst) begin
      p     <= '0;
      waste <= '0;
    end else begin
      p     <= prod_d;
      waste <= waste_d;
    end
  end

  AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> p == ({{OP_W{1'b0}}, $past(a)} * {{OP_W{1'b0}}, $past(b)})); // R1

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (p == '0 && waste == '0)); // R2

  AST_LOW_PAIR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (p[0] == ($past(a[0]) & $past(b[0])) &&
                     p[1] == (($past(a[1]) & $past(b[0])) ^ ($past(a[0]) & $past(b[1]))))); // R3

  AST_ADDER_HEADROOM: assert property (@(posedge clk) disable iff (rst)
    (s1[SUB_W] == 1'b0 && s3[SUB_W] == 1'b0)); // R5

endmodule

// File: tb/rvm_mul4_bench.sv
`timescale 1ns/1ps
module rvm_mul4_bench;
  import rvm_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] a = '0, b = '0;
  logic [7:0] p;
  logic [WASTE_W-1:0] waste;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rvm_mul4 u_rvm_mul4 (.clk(clk), .rst(rst), .a(a), .b(b), .p(p), .waste(waste));

  logic [1:0] cn_i, cn_o;
  logic [2:0] tf_i, tf_o, pr_i, pr_o, sx_i, sx_o;
  logic [3:0] fa_i, fa_o;
  logic [4:0] da_i, da_o;
  rvm_gate #(.KIND(GK_CNOT))    g_cn (.in_i(cn_i), .out_o(cn_o));
  rvm_gate #(.KIND(GK_TOFFOLI)) g_tf (.in_i(tf_i), .out_o(tf_o));
  rvm_gate #(.KIND(GK_PERES))   g_pr (.in_i(pr_i), .out_o(pr_o));
  rvm_gate #(.KIND(GK_SWAPXOR)) g_sx (.in_i(sx_i), .out_o(sx_o));
  rvm_gate #(.KIND(GK_FULLADD)) g_fa (.in_i(fa_i), .out_o(fa_o));
  rvm_gate #(.KIND(GK_DUALAND)) g_da (.in_i(da_i), .out_o(da_o));

  logic [1:0] ca, cb;
  logic [3:0] cq;
  logic [4:0] cj;
  rvm_cell2 u_cell (.a_i(ca), .b_i(cb), .q_o(cq), .junk_o(cj));

  logic [3:0] ax, ay;
  logic [4:0] as;
  logic [6:0] aj;
  rvm_radd #(.W(4)) u_add (.x_i(ax), .y_i(ay), .sum_o(as), .junk_o(aj));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seen;
    logic [4:0] e;
    int m;

    // R7: controlled-NOT equations and bijection (R6)
    seen = '0;
    for (int v = 0; v < 4; v++) begin
      cn_i = 2'(v); #1;
      e = {3'b0, cn_i[0] ^ cn_i[1], cn_i[0]};
      chk(cn_o == e[1:0], "R7 cnot", cn_o, e);
      chk(!seen[cn_o], "R6 cnot one-to-one", cn_o, v);
      seen[cn_o] = 1'b1;
    end
    // R7: Toffoli
    seen = '0;
    for (int v = 0; v < 8; v++) begin
      tf_i = 3'(v); #1;
      e = {2'b0, (tf_i[0] & tf_i[1]) ^ tf_i[2], tf_i[1], tf_i[0]};
      chk(tf_o == e[2:0], "R7 toffoli", tf_o, e);
      chk(!seen[tf_o], "R6 toffoli one-to-one", tf_o, v);
      seen[tf_o] = 1'b1;
    end
    // R8: Peres
    seen = '0;
    for (int v = 0; v < 8; v++) begin
      pr_i = 3'(v); #1;
      e = {2'b0, (pr_i[0] & pr_i[1]) ^ pr_i[2], pr_i[0] ^ pr_i[1], pr_i[0]};
      chk(pr_o == e[2:0], "R8 peres", pr_o, e);
      chk(!seen[pr_o], "R6 peres one-to-one", pr_o, v);
      seen[pr_o] = 1'b1;
    end
    // R10: swap-xor
    seen = '0;
    for (int v = 0; v < 8; v++) begin
      logic q;
      sx_i = 3'(v); #1;
      q = sx_i[0] ? sx_i[2] : sx_i[1];
      e = {2'b0, sx_i[0] ? sx_i[1] : sx_i[2], q, sx_i[0] ^ q};
      chk(sx_o == e[2:0], "R10 swapxor", sx_o, e);
      chk(!seen[sx_o], "R6 swapxor one-to-one", sx_o, v);
      seen[sx_o] = 1'b1;
    end
    // R9: full-adder gate, carry/sum computed arithmetically
    seen = '0;
    for (int v = 0; v < 16; v++) begin
      int t;
      fa_i = 4'(v); #1;
      t = int'(fa_i[0]) + int'(fa_i[1]) + int'(fa_i[2]);
      e = {1'b0, fa_i[3] ^ (t >= 2), t[0], fa_i[1], fa_i[0]};
      chk(fa_o == e[3:0], "R9 fulladd", fa_o, e);
      chk(!seen[fa_o], "R6 fulladd one-to-one", fa_o, v);
      seen[fa_o] = 1'b1;
    end
    // R10: dual-product gate
    seen = '0;
    for (int v = 0; v < 32; v++) begin
      da_i = 5'(v); #1;
      e = {(da_i[0] & da_i[3]) ^ da_i[4], da_i[3], (da_i[0] & da_i[1]) ^ da_i[2], da_i[1], da_i[0]};
      chk(da_o == e, "R10 dualand", da_o, e);
      chk(!seen[da_o], "R6 dualand one-to-one", da_o, v);
      seen[da_o] = 1'b1;
    end
    // R4: 2x2 cell
    for (int v = 0; v < 16; v++) begin
      ca = v[1:0]; cb = v[3:2]; #1;
      m = int'(ca) * int'(cb);
      chk(int'(cq) == m, "R4 cell product", cq, m);
    end
    // R5: 4-bit reversible adder
    for (int v = 0; v < 256; v++) begin
      ax = v[3:0]; ay = v[7:4]; #1;
      m = int'(ax) + int'(ay);
      chk(int'(as) == m, "R5 adder sum", as, m);
    end

    // R2: reset state
    @(negedge clk);
    @(negedge clk);
    chk(p == 8'd0 && waste == '0, "R2 reset state", p, 0);
    rst = 1'b0;

    // R1, R3: exhaustive sweep
    for (int v = 0; v < 256; v++) begin
      a = v[3:0]; b = v[7:4];
      @(posedge clk);
      @(negedge clk);
      m = int'(a) * int'(b);
      chk(int'(p) == m, "R1 product", p, m);
      chk(p[1:0] == 2'(int'(a[1:0]) * int'(b[1:0])), "R3 low bits", p[1:0], (int'(a[1:0]) * int'(b[1:0])) % 4);
    end

    // R2 against R1 on the same edge: largest operands with reset high
    a = 4'hF; b = 4'hF; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(p == 8'd0 && waste == '0, "R2 reset beats capture", p, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(p == 8'd225, "R1 first capture after reset", p, 225);

    done = 1;
    summary();
    $finish;
  end

endmodule